// File: doc/BRIEF.md
# Bus Transaction Sequencer for a Debug Command Path

This block carries out bus work for a debug command that has already been decoded. A command names one of three actions (read, write or initialize), a start address, one write word and a repeat count. The sequencer first asks for the bus and waits for a grant. It then runs single-word cycles at rising addresses, one per repeat. For each cycle it reports whether the slave acknowledged, signalled an error, or stayed silent until a watchdog expired. A formatting stage further down the path uses these reports, together with any read data, to build the text shown to the operator.

An initialize command does not move data. Once the bus is granted, the sequencer holds a bus reset line for a fixed number of clocks. Every command ends with a one-clock completion pulse that carries the final status. The first error or timeout stops the command, and the remaining repeats are dropped. Address width and data width are separate parameters. Every transfer moves one whole data word: there are no byte lanes, no bursts and no reordering.

Top module: `dbg_bus_seq`

## Requirements
- R1: `bus_req` is high from the clock after a command is accepted until the command completes. `bus_cyc` rises only after a clock in which `bus_gnt` was high.
- R2: A command with count N (N ≥ 1) runs exactly N transfers, at addresses start, start+1, …, start+N−1. A count of 0 runs one transfer at the start address.
- R3: Every transfer is one full data word. A write drives `bus_we` high and places `cmd_wdata` on `bus_dat_o`. For a read that is acknowledged, `rsp_data` carries the word that was on `bus_dat_i` in the acknowledge clock.
- R4: Each finished transfer gives exactly one `rsp_valid` pulse, with `rsp_addr` set to the transfer address and `rsp_status` set to 0 for an acknowledge, 1 for an error or 2 for a timeout. If error and acknowledge arrive together, the error wins.
- R5: If a strobe gets neither acknowledge nor error, the cycle ends after exactly TO_LIMIT clocks of strobe and is reported with status 2.
- R6: An initialize command (`cmd_kind` = 2'b10 or 2'b11) raises `bus_rst` for exactly RST_CYCLES clocks once the bus is granted. It never raises `bus_cyc` and produces no `rsp_valid`. It completes with status 0.
- R7: `bus_cyc` and `bus_stb` stay high, with a steady address, until a response or a timeout. Between two transfers of one command they are low for at least one clock.
- R8: The first transfer with status 1 or 2 ends the command: no further transfers are run, and `done` pulses with `done_status` equal to that status. If every transfer is acknowledged, `done_status` is 0.
- R9: `bus_req` is already low in the clock where `done` is shown. `cmd_ready` is high only while no command is in progress.
- R10: While reset is held, and after reset, `bus_req`, `bus_cyc`, `bus_stb`, `bus_rst`, `rsp_valid` and `done` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The sequencer is idle and takes the offered command |
| cmd_kind | input | 2 | 0 read, 1 write, 2 or 3 initialize |
| cmd_addr | input | AW | Start address |
| cmd_wdata | input | DW | Word written by each write transfer |
| cmd_count | input | CW | Number of repeats (0 counts as 1) |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_stb | output | 1 | Transfer strobe |
| bus_we | output | 1 | High for a write transfer |
| bus_adr | output | AW | Transfer address, zero when idle |
| bus_dat_o | output | DW | Write data, zero when not writing |
| bus_dat_i | input | DW | Read data from the slave |
| bus_ack | input | 1 | Slave acknowledge |
| bus_err | input | 1 | Slave error |
| bus_rst | output | 1 | Bus reset driven by an initialize command |
| rsp_valid | output | 1 | One-clock pulse per finished transfer |
| rsp_status | output | 2 | 0 acknowledge, 1 error, 2 timeout |
| rsp_addr | output | AW | Address of the finished transfer |
| rsp_data | output | DW | Read word (or written word for a write) |
| done | output | 1 | One-clock pulse when the command ends |
| done_status | output | 2 | Final status of the command, same coding as rsp_status |

## Verification
The assertions assume that the slave raises `bus_ack` or `bus_err` only while a strobe is active. They also assume that the arbiter keeps a grant, once given, at least until the current strobe ends. The bench slave is built on these terms. It answers only an active strobe, it clears its response in the clock after it raises it, and it stays silent for one address region so that the watchdog path is exercised. For all other addresses its wait of up to three clocks stays well inside TO_LIMIT. The grant is changed only while no strobe is active, so the assumption about holding the grant is never broken.

// File: rtl/dbg_seq_pkg.sv
`timescale 1ns/1ps
package dbg_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_CYC,
        S_GAP,
        S_RST
    } seq_state_e;

    localparam logic [1:0] KIND_READ  = 2'd0;
    localparam logic [1:0] KIND_WRITE = 2'd1;

    localparam logic [1:0] RSP_OK  = 2'd0;
    localparam logic [1:0] RSP_ERR = 2'd1;
    localparam logic [1:0] RSP_TMO = 2'd2;

endpackage

// File: rtl/dbg_seq_addr_gen.sv
`timescale 1ns/1ps
module dbg_seq_addr_gen #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] count,
    output logic [AW-1:0] addr,
    output logic          last
);

    logic [AW-1:0] addr_d, addr_q;
    logic [CW-1:0] rem_d, rem_q;

    always_comb begin
        addr_d = addr_q;
        rem_d  = rem_q;
        if (load) begin
            addr_d = start_addr;
            rem_d  = (count == '0) ? '0 : count - CW'(1);
        end else if (step) begin
            addr_d = addr_q + AW'(1);
            rem_d  = rem_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else begin
            addr_q <= addr_d;
            rem_q  <= rem_d;
        end
    end

    assign addr = addr_q;
    assign last = (rem_q == '0);

endmodule

// File: rtl/dbg_seq_watchdog.sv
`timescale 1ns/1ps
module dbg_seq_watchdog #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);

    localparam int CNTW = $clog2(LIMIT + 1);

    logic [CNTW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = active ? cnt_q + CNTW'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = active && (cnt_q == CNTW'(LIMIT - 1));

endmodule

// File: rtl/dbg_bus_seq.sv
`timescale 1ns/1ps
module dbg_bus_seq
    import dbg_seq_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int CW         = 8,
    parameter int TO_LIMIT   = 16,
    parameter int RST_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_kind,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [CW-1:0] cmd_count,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_cyc,
    output logic          bus_stb,
    output logic          bus_we,
    output logic [AW-1:0] bus_adr,
    output logic [DW-1:0] bus_dat_o,
    input  logic [DW-1:0] bus_dat_i,
    input  logic          bus_ack,
    input  logic          bus_err,
    output logic          bus_rst,
    output logic          rsp_valid,
    output logic [1:0]    rsp_status,
    output logic [AW-1:0] rsp_addr,
    output logic [DW-1:0] rsp_data,
    output logic          done,
    output logic [1:0]    done_status
);

    localparam int RW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        seq_state_e    st;
        logic          we;
        logic          init;
        logic [DW-1:0] wdat;
        logic [RW-1:0] rcnt;
        logic          rsp_v;
        logic [1:0]    rsp_code;
        logic [AW-1:0] rsp_adr;
        logic [DW-1:0] rsp_dat;
        logic          done;
        logic [1:0]    done_code;
    } seq_t;

    seq_t          q, d;
    logic          load, step, last, expired, in_cyc;
    logic [AW-1:0] addr;
    logic [1:0]    code;

    assign in_cyc = (q.st == S_CYC);

    dbg_seq_addr_gen #(.AW(AW), .CW(CW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .start_addr (cmd_addr),
        .count      (cmd_count),
        .addr       (addr),
        .last       (last)
    );

    dbg_seq_watchdog #(.LIMIT(TO_LIMIT)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (in_cyc),
        .expired (expired)
    );

    // response code: error beats acknowledge, acknowledge beats timeout
    always_comb begin
        if (bus_err)      code = RSP_ERR;
        else if (bus_ack) code = RSP_OK;
        else              code = RSP_TMO;
    end

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        d.done  = 1'b0;
        load    = 1'b0;
        step    = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    load   = 1'b1;
                    d.we   = (cmd_kind == KIND_WRITE);
                    d.init = cmd_kind[1];
                    d.wdat = cmd_wdata;
                    d.rcnt = '0;
                    d.st   = S_REQ;
                end
            end
            S_REQ: begin
                if (bus_gnt) d.st = q.init ? S_RST : S_CYC;
            end
            S_CYC: begin
                if (bus_ack || bus_err || expired) begin
                    d.rsp_v    = 1'b1;
                    d.rsp_code = code;
                    d.rsp_adr  = addr;
                    if (q.we)                d.rsp_dat = q.wdat;
                    else if (code == RSP_OK) d.rsp_dat = bus_dat_i;
                    else                     d.rsp_dat = '0;
                    if ((code != RSP_OK) || last) begin
                        d.st        = S_IDLE;
                        d.done      = 1'b1;
                        d.done_code = code;
                    end else begin
                        d.st = S_GAP;
                        step = 1'b1;
                    end
                end
            end
            S_GAP: begin
                d.st = bus_gnt ? S_CYC : S_REQ;
            end
            S_RST: begin
                d.rcnt = q.rcnt + RW'(1);
                if (q.rcnt == RW'(RST_CYCLES - 1)) begin
                    d.st        = S_IDLE;
                    d.done      = 1'b1;
                    d.done_code = RSP_OK;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= S_IDLE;
            q.we        <= 1'b0;
            q.init      <= 1'b0;
            q.wdat      <= '0;
            q.rcnt      <= '0;
            q.rsp_v     <= 1'b0;
            q.rsp_code  <= RSP_OK;
            q.rsp_adr   <= '0;
            q.rsp_dat   <= '0;
            q.done      <= 1'b0;
            q.done_code <= RSP_OK;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready   = (q.st == S_IDLE);
    assign bus_req     = (q.st != S_IDLE);
    assign bus_cyc     = in_cyc;
    assign bus_stb     = in_cyc;
    assign bus_we      = in_cyc && q.we;
    assign bus_adr     = in_cyc ? addr : '0;
    assign bus_dat_o   = (in_cyc && q.we) ? q.wdat : '0;
    assign bus_rst     = (q.st == S_RST);
    assign rsp_valid   = q.rsp_v;
    assign rsp_status  = q.rsp_code;
    assign rsp_addr    = q.rsp_adr;
    assign rsp_data    = q.rsp_dat;
    assign done        = q.done;
    assign done_status = q.done_code;

endmodule

// File: rtl/dbg_bus_seq_chk.sv
`timescale 1ns/1ps
module dbg_bus_seq_chk #(
    parameter int AW       = 16,
    parameter int TO_LIMIT = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          bus_cyc,
    input logic          bus_stb,
    input logic [AW-1:0] bus_adr,
    input logic          bus_rst,
    input logic          rsp_valid,
    input logic [1:0]    rsp_status,
    input logic          done
);

    localparam int RUNW = $clog2(TO_LIMIT + 2) + 1;

    logic [RUNW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (bus_stb) run_q <= run_q + RUNW'(1);
        else              run_q <= '0;
    end

    AST_CYC_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cyc) |-> $past(bus_gnt)) else $error("cyc without grant"); // R1

    AST_CYC_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> bus_req) else $error("cyc without request"); // R1

    AST_STB_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb |-> (run_q < RUNW'(TO_LIMIT))) else $error("strobe too long"); // R5

    AST_RST_NO_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |-> !bus_cyc) else $error("reset with cycle"); // R6

    AST_STB_ENDS_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_stb) |-> rsp_valid) else $error("strobe dropped silently"); // R7

    AST_GAP_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !bus_stb) else $error("no gap"); // R7

    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && $past(bus_stb)) |-> $stable(bus_adr)) else $error("addr moved"); // R7

    AST_FAIL_ENDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_status != 2'd0)) |-> done) else $error("fail not final"); // R8

    AST_DONE_RELEASES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req) else $error("request held at done"); // R9

endmodule

bind dbg_bus_seq dbg_bus_seq_chk #(.AW(AW), .TO_LIMIT(TO_LIMIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_cyc    (bus_cyc),
    .bus_stb    (bus_stb),
    .bus_adr    (bus_adr),
    .bus_rst    (bus_rst),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .done       (done)
);

// File: tb/dbg_bus_seq_test.sv
`timescale 1ns/1ps
module dbg_bus_seq_test;

    localparam int AW = 16, DW = 16, CW = 8, TO_LIMIT = 16, RST_CYCLES = 4;
    localparam int NV = 8;

    // vector table: kind, address, data, count, final status, response count
    localparam logic [1:0]  VK [NV] = '{2'd1, 2'd1, 2'd0, 2'd0, 2'd0, 2'd1, 2'd0, 2'd2};
    localparam logic [15:0] VA [NV] = '{16'h0002, 16'h0005, 16'h0001, 16'h00E0,
                                        16'h00FE, 16'h00DE, 16'h000E, 16'h0000};
    localparam logic [15:0] VD [NV] = '{16'h1111, 16'hABCD, 16'h0, 16'h0,
                                        16'h0, 16'h5A5A, 16'h0, 16'h0};
    localparam logic [7:0]  VC [NV] = '{8'd3, 8'd0, 8'd5, 8'd2, 8'd4, 8'd4, 8'd3, 8'd0};
    localparam logic [1:0]  VS [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd1, 2'd0, 2'd0};
    localparam int          VN [NV] = '{3, 1, 5, 1, 1, 3, 3, 0};

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_ready;
    logic [1:0] cmd_kind = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic [CW-1:0] cmd_count = '0;
    logic bus_req, bus_gnt = 1'b1, bus_cyc, bus_stb, bus_we, bus_rst;
    logic [AW-1:0] bus_adr;
    logic [DW-1:0] bus_dat_o, bus_dat_i;
    logic bus_ack, bus_err;
    logic rsp_valid, done;
    logic [1:0] rsp_status, done_status;
    logic [AW-1:0] rsp_addr;
    logic [DW-1:0] rsp_data;

    always #2.5 clk = ~clk;

    dbg_bus_seq #(.AW(AW), .DW(DW), .CW(CW), .TO_LIMIT(TO_LIMIT),
                  .RST_CYCLES(RST_CYCLES)) uut (.*);

    // slave: 16 words, region E errors, region F never answers, wait = adr[1:0]
    logic [DW-1:0] smem [16];
    logic [1:0] swait;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ack <= 1'b0; bus_err <= 1'b0; swait <= '0; bus_dat_i <= '0;
            for (int i = 0; i < 16; i++) smem[i] <= 16'(i * 16'h0101);
        end else if (bus_cyc && bus_stb && !bus_ack && !bus_err) begin
            if (bus_adr[7:4] != 4'hF) begin
                if (swait == bus_adr[1:0]) begin
                    swait <= '0;
                    if (bus_adr[7:4] == 4'hE) bus_err <= 1'b1;
                    else begin
                        bus_ack <= 1'b1;
                        bus_dat_i <= smem[bus_adr[3:0]];
                        if (bus_we) smem[bus_adr[3:0]] <= bus_dat_o;
                    end
                end else swait <= swait + 2'd1;
            end
        end else begin
            bus_ack <= 1'b0; bus_err <= 1'b0;
            if (!bus_stb) swait <= '0;
        end
    end

    // monitor
    logic [1:0]  m_code [32];
    logic [15:0] m_adr [32], m_dat [32];
    int m_len [32];
    int m_n, stb_run, stb_rises, rst_len, gap_viol;
    bit cyc_seen, done_seen, req_at_done, prev_stb;
    logic [1:0] m_done_code;

    always @(negedge clk) begin
        if (rsp_valid && m_n < 32) begin
            m_code[m_n] = rsp_status; m_adr[m_n] = rsp_addr;
            m_dat[m_n] = rsp_data; m_len[m_n] = stb_run; m_n++;
        end
        if (bus_stb && !prev_stb) stb_rises++;
        if (bus_stb) stb_run++; else stb_run = 0;
        prev_stb = bus_stb;
        if (bus_rst) rst_len++;
        if (bus_cyc) cyc_seen = 1;
        if (done) begin
            done_seen = 1; m_done_code = done_status; req_at_done = bus_req;
        end
    end

    int tests = 0, fails = 0, cycles = 0;
    logic [15:0] ref_mem [16];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic clear_mon();
        @(posedge clk); #1;
        m_n = 0; stb_rises = 0; rst_len = 0; cyc_seen = 0; done_seen = 0;
    endtask

    task automatic issue(input logic [1:0] k, input logic [15:0] a,
                         input logic [15:0] w, input logic [7:0] c);
        clear_mon();
        @(negedge clk);
        cmd_kind = k; cmd_addr = a; cmd_wdata = w; cmd_count = c; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_seen && n < 2000) begin @(negedge clk); n++; end
        chk(done_seen, "R8 done pulse", 32'(done_seen), 1);
        @(negedge clk);
    endtask

    function automatic logic [1:0] exp_code(input logic [15:0] a);
        if (a[7:4] == 4'hE) return 2'd1;
        if (a[7:4] == 4'hF) return 2'd2;
        return 2'd0;
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) ref_mem[i] = 16'(i * 16'h0101);
        #1;
        chk(!bus_req && !bus_cyc && !rsp_valid && !done && !bus_rst,
            "R10 outputs in reset", {bus_req, bus_cyc, rsp_valid, done}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !bus_req && !bus_stb, "R10 idle after reset",
            {cmd_ready, bus_req, bus_stb}, 3'b100);

        // table walk
        for (int v = 0; v < NV; v++) begin
            int eff, nexp;
            logic [1:0] fin;
            issue(VK[v], VA[v], VD[v], VC[v]);
            chk(!cmd_ready && bus_req, "R9 busy while running", {cmd_ready, bus_req}, 2'b01);
            wait_done();
            eff = (VC[v] == 0) ? 1 : int'(VC[v]);
            nexp = 0; fin = 2'd0;
            if (VK[v][1]) begin
                chk(rst_len == RST_CYCLES, "R6 reset length", rst_len, RST_CYCLES);
                chk(!cyc_seen && m_n == 0, "R6 no transfer", m_n, 0);
            end else begin
                for (int i = 0; i < eff; i++) begin
                    logic [15:0] a;
                    logic [1:0] ec;
                    a = VA[v] + 16'(i);
                    ec = exp_code(a);
                    nexp++;
                    if (i < m_n) begin
                        chk(m_adr[i] == a, "R2 address sequence", m_adr[i], a);
                        chk(m_code[i] == ec, "R4 status", m_code[i], ec);
                        if (ec == 2'd2)
                            chk(m_len[i] == TO_LIMIT, "R5 timeout length", m_len[i], TO_LIMIT);
                        else
                            chk(m_len[i] >= 1 && m_len[i] < TO_LIMIT, "R7 strobe held",
                                m_len[i], 1);
                        if (ec == 2'd0 && VK[v] == 2'd0)
                            chk(m_dat[i] == ref_mem[a[3:0]], "R3 read data",
                                m_dat[i], ref_mem[a[3:0]]);
                    end
                    if (ec == 2'd0 && VK[v] == 2'd1) ref_mem[a[3:0]] = VD[v];
                    if (ec != 2'd0) begin fin = ec; break; end
                end
                chk(m_n == nexp && nexp == VN[v], "R2 R8 transfer count", m_n, nexp);
                chk(stb_rises == m_n, "R7 separate strobes", stb_rises, m_n);
            end
            chk(m_done_code == fin && fin == VS[v], "R8 final status", m_done_code, fin);
            chk(!req_at_done, "R9 request released", 32'(req_at_done), 0);
        end

        // readback of every word written by the table
        issue(2'd0, 16'h0000, 16'h0, 8'd16);
        wait_done();
        chk(m_n == 16, "R2 readback count", m_n, 16);
        for (int i = 0; i < 16 && i < m_n; i++)
            chk(m_dat[i] == ref_mem[i], "R3 written words", m_dat[i], ref_mem[i]);

        // grant withheld
        bus_gnt = 1'b0;
        issue(2'd0, 16'h0003, 16'h0, 8'd1);
        repeat (10) @(negedge clk);
        chk(!cyc_seen && bus_req, "R1 wait for grant", {cyc_seen, bus_req}, 2'b01);
        bus_gnt = 1'b1;
        wait_done();
        chk(m_n == 1 && m_code[0] == 2'd0, "R1 runs after grant", m_n, 1);

        // write word on the bus
        issue(2'd1, 16'h0007, 16'hC3C3, 8'd1);
        while (!bus_stb) @(negedge clk);
        chk(bus_we && bus_dat_o == 16'hC3C3, "R3 write word driven", bus_dat_o, 16'hC3C3);
        wait_done();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule